// File: doc/BRIEF.md
# Integer-Ratio Clock Crossing FIFO

This block is a first-in first-out buffer between a producer and a consumer that run on two different clocks. The two clocks are related by a whole-number frequency ratio, and their rising edges are aligned. Because every edge of the slower clock falls on an edge of the faster one, no gray-coded pointers or multi-flop synchronizers are used. All storage and bookkeeping run on the fast clock. The fast logic derives, from a toggle flop on the slow clock, a one-cycle strobe that marks the fast cycle ending on the next shared edge. Transfers requested by the slow side are taken only on that strobe.

Either side can be the fast one. The parameter `WR_FAST` selects this, and `RATIO` gives how many fast cycles make one slow cycle (2 or more). The read port shows the oldest word whenever the empty flag is low, so the data arrives first and the read enable acknowledges it. Each flag is a register that changes only on an active edge of its own side. The flag on the slow side therefore shows occupancy as it stood at the last shared edge. It may lag toward caution, but it never claims room or data that does not exist.

Top module: `ratio_clk_fifo`

## Requirements
- R1: With `rst_n` low (asynchronous, active low) the buffer is emptied: `rd_empty` is 1, and `wr_full` is 0 when the write side is the fast one (`WR_FAST`=1) or 1 when it is the slow one.
- R2: Whenever `rd_empty` is 0, `rd_data` carries the oldest accepted word that has not yet been read, and words leave in the order they were accepted.
- R3: A transfer requested by the slow side is taken only at a fast rising edge that coincides with a slow rising edge, and at most once per slow cycle. The fast-domain strobe that marks it is never high in two consecutive fast cycles.
- R4: A write requested while `wr_full` is 1 is ignored: occupancy and stored contents are unchanged.
- R5: A read requested while `rd_empty` is 1 is ignored: occupancy and the read position are unchanged.
- R6: `wr_full` is 1 whenever the buffer holds `DEPTH` words, and occupancy never exceeds `DEPTH`.
- R7: `rd_empty` is 1 whenever the buffer holds no word.
- R8: The flag of the fast side equals the occupancy after every fast edge. The flag of the slow side changes only on shared edges and then equals the occupancy after that edge, so it lags by at most one slow cycle.
- R9: After reset is released, the slow side sees a cautious flag (empty, or full for a slow writer) and no transfer of its own is taken until the strobe has locked onto the slow clock phase.
- R10: While `rd_empty` is 0 and no read is taken, `rd_data` does not change.
- R11: A `DEPTH` that is not a power of two is supported: pointers wrap from `DEPTH`-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr | input | 1 | Write-side clock, rising edge |
| clk_rd | input | 1 | Read-side clock, rising edge, edge-aligned with `clk_wr` at an integer ratio |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request, sampled on write-side edges |
| wr_data | input | WIDTH | Word to write |
| wr_full | output | 1 | No room for a write |
| rd_en | input | 1 | Read acknowledge, sampled on read-side edges |
| rd_data | output | WIDTH | Oldest stored word |
| rd_empty | output | 1 | No word available |

## Verification
The bench goes after three things: the slow side's flag timing at the shared edge, the lock period right after reset, and the two saturation points.

- **Shared-edge timing.** A strobe placed one fast cycle early or late would let the slow reader take a word in the wrong cycle. The empty flag would then update off its shared edge, and that shows up as a flag or data mismatch on a fast cycle in mid slow period.
- **Lock period after reset.** A design that trusts its phase counter before it has seen the slow clock toggle would expose data during that window.
- **Saturation points.** The bench fills past `DEPTH` and drains past empty. A design that counts an ignored write or read would corrupt the word order, or wrap its pointers wrongly at the non-power-of-two depth.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    typedef enum logic {
        SIDE_SLOW = 1'b0,
        SIDE_FAST = 1'b1
    } side_e;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
    } xfer_t;

    function automatic int unsigned wrap_step(input int unsigned pos,
                                              input int unsigned depth);
        return (pos + 1 >= depth) ? 0 : pos + 1;
    endfunction

    function automatic side_e side_of(input bit is_fast);
        return is_fast ? SIDE_FAST : SIDE_SLOW;
    endfunction

endpackage

// File: rtl/rcf_edge_strobe.sv
module rcf_edge_strobe #(
    parameter int RATIO = 3
) (
    input  logic clk_fast,
    input  logic clk_slow,
    input  logic rst_n,
    output logic stb
);
    localparam int PW = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    logic          tog;
    logic          tog_q;
    logic          locked;
    logic [PW-1:0] phase;

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) tog <= 1'b0;
        else        tog <= ~tog;
    end

    // phase counts fast edges since the last shared edge
    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            tog_q  <= 1'b0;
            locked <= 1'b0;
            phase  <= '0;
        end else begin
            tog_q <= tog;
            if (tog != tog_q) begin
                locked <= 1'b1;
                phase  <= PW'(1 % RATIO);
            end else if (phase == LAST) begin
                phase <= '0;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    assign stb = locked && (phase == LAST);
endmodule

// File: rtl/rcf_store.sv
module rcf_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 6,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rcf_ctrl.sv
module rcf_ctrl
    import rcf_pkg::*;
#(
    parameter int    DEPTH   = 6,
    parameter int    AW      = 3,
    parameter int    CW      = 3,
    parameter side_e WR_SIDE = SIDE_FAST
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          wr_stb,
    input  logic          rd_stb,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          wr_full,
    output logic          rd_empty,
    output logic [CW-1:0] occ,
    output xfer_t         xf
);
    localparam logic          FULL_RST = (WR_SIDE == SIDE_FAST) ? 1'b0 : 1'b1;
    localparam logic [CW-1:0] TOP      = CW'(DEPTH);

    logic [CW-1:0] occ_nxt;

    always_comb begin
        xf.wr_ok = wr_en & wr_stb & ~wr_full;
        xf.rd_ok = rd_en & rd_stb & ~rd_empty;
        occ_nxt  = occ + CW'(xf.wr_ok) - CW'(xf.rd_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            occ      <= '0;
            wr_full  <= FULL_RST;
            rd_empty <= 1'b1;
        end else begin
            if (xf.wr_ok) wr_ptr <= AW'(wrap_step(32'(wr_ptr), DEPTH));
            if (xf.rd_ok) rd_ptr <= AW'(wrap_step(32'(rd_ptr), DEPTH));
            occ <= occ_nxt;
            if (wr_stb) wr_full  <= (occ_nxt == TOP);
            if (rd_stb) rd_empty <= (occ_nxt == '0);
        end
    end
endmodule

// File: rtl/ratio_clk_fifo.sv
module ratio_clk_fifo
    import rcf_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int DEPTH   = 6,
    parameter int RATIO   = 3,
    parameter bit WR_FAST = 1'b1
) (
    input  logic             clk_wr,
    input  logic             clk_rd,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_full,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_empty
);
    localparam int    AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int    CW      = $clog2(DEPTH + 1);
    localparam side_e WR_SIDE = side_of(WR_FAST);

    logic          clk_fast;
    logic          clk_slow;
    logic          slow_stb;
    logic          wr_stb;
    logic          rd_stb;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] occ;
    xfer_t         xf;
    logic          wr_ok;
    logic          rd_ok;

    generate
        if (WR_SIDE == SIDE_FAST) begin : g_wr_fast
            assign clk_fast = clk_wr;
            assign clk_slow = clk_rd;
            assign wr_stb   = 1'b1;
            assign rd_stb   = slow_stb;
        end else begin : g_rd_fast
            assign clk_fast = clk_rd;
            assign clk_slow = clk_wr;
            assign wr_stb   = slow_stb;
            assign rd_stb   = 1'b1;
        end
    endgenerate

    rcf_edge_strobe #(.RATIO(RATIO)) u_strobe (
        .clk_fast (clk_fast),
        .clk_slow (clk_slow),
        .rst_n    (rst_n),
        .stb      (slow_stb)
    );

    rcf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .WR_SIDE(WR_SIDE)) u_ctrl (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .wr_full  (wr_full),
        .rd_empty (rd_empty),
        .occ      (occ),
        .xf       (xf)
    );

    assign wr_ok = xf.wr_ok;
    assign rd_ok = xf.rd_ok;

    rcf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk_fast),
        .we    (wr_ok),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/ratio_clk_fifo_chk.sv
module ratio_clk_fifo_chk #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 6,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             wr_full,
    input logic             rd_empty,
    input logic [WIDTH-1:0] rd_data,
    input logic [CW-1:0]    occ,
    input logic             wr_stb,
    input logic             rd_stb,
    input logic             wr_ok,
    input logic             rd_ok,
    input logic             slow_stb
);
    a_r6_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    a_r6_full_when_packed: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH)) |-> wr_full);

    a_r7_empty_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> rd_empty);

    a_r3_strobe_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        slow_stb |=> !slow_stb);

    a_r4_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_stb && wr_full && !rd_ok) |=> (occ == $past(occ)));

    a_r5_empty_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_stb && rd_empty && !wr_ok) |=> (occ == $past(occ)));

    a_r8_full_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(wr_full));

    a_r8_empty_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_empty));

    a_r10_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_empty && !rd_ok) |=> $stable(rd_data));
endmodule

bind ratio_clk_fifo ratio_clk_fifo_chk #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)
) u_chk (
    .clk      (clk_fast),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_full  (wr_full),
    .rd_empty (rd_empty),
    .rd_data  (rd_data),
    .occ      (occ),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .slow_stb (slow_stb)
);

// File: tb/ratio_clk_fifo_bench.sv
`timescale 1ns/1ps
module ratio_clk_fifo_bench;
    localparam int WIDTH   = 16;
    localparam int DEPTH   = 6;
    localparam int RATIO   = 3;
    localparam bit WR_FAST = 1'b1;

    logic clk_f, clk_s, slow_rise;
    int   hc;
    logic clk_wr, clk_rd, rst_n;
    logic wr_en, rd_en, wr_full, rd_empty;
    logic [WIDTH-1:0] wr_data, rd_data;

    int total = 0;
    int bad   = 0;

    logic [WIDTH-1:0] mq[$];
    bit mfull, mempty, se_last;

    assign clk_wr = WR_FAST ? clk_f : clk_s;
    assign clk_rd = WR_FAST ? clk_s : clk_f;

    ratio_clk_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .RATIO(RATIO), .WR_FAST(WR_FAST)) u_ratio_clk_fifo (
        .clk_wr(clk_wr), .clk_rd(clk_rd), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
    );

    // 100 MHz fast clock; slow rising edges land on fast rising edges
    initial begin
        clk_f = 0; clk_s = 0; slow_rise = 0; hc = 0;
        forever begin
            #5;
            hc++;
            slow_rise = 0;
            if ((hc - 1) % RATIO == 0) begin
                clk_s = ~clk_s;
                slow_rise = clk_s;
            end
            clk_f = ~clk_f;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // one fast cycle; optionally advance the model and compare
    task automatic cyc(input bit do_model);
        bit se, wst, rst_s, wok, rok;
        @(posedge clk_f);
        se = slow_rise;
        if (do_model) begin
            wst   = WR_FAST || se;
            rst_s = !WR_FAST || se;
            wok   = wr_en && wst && !mfull;
            rok   = rd_en && rst_s && !mempty;
            if (rok) void'(mq.pop_front());
            if (wok) mq.push_back(wr_data);
            if (wst)   mfull  = (mq.size() == DEPTH);
            if (rst_s) mempty = (mq.size() == 0);
        end
        se_last = se;
        @(negedge clk_f);
        if (do_model) begin
            chk(wr_full == mfull, "R6/R8 wr_full", 32'(wr_full), 32'(mfull));
            chk(rd_empty == mempty, "R3/R7/R8 rd_empty", 32'(rd_empty), 32'(mempty));
            if (!mempty && mq.size() > 0)
                chk(rd_data == mq[0], "R2/R10/R11 rd_data", 32'(rd_data), 32'(mq[0]));
        end
    endtask

    // inputs of a side change only right after that side's edge
    task automatic set_inputs(input int wp, input int rp);
        if (WR_FAST || se_last) begin
            wr_en   = ($urandom % 100) < wp;
            wr_data = WIDTH'($urandom);
        end
        if (!WR_FAST || se_last) rd_en = ($urandom % 100) < rp;
    endtask

    task automatic run(input int n, input int wp, input int rp);
        for (int i = 0; i < n; i++) begin
            set_inputs(wp, rp);
            cyc(1);
        end
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [WIDTH-1:0] first_word;
        void'($urandom(32'd1234));
        rst_n = 0; wr_en = 0; rd_en = 0; wr_data = '0; se_last = 0;
        repeat (3) @(negedge clk_f);
        chk(rd_empty == 1'b1, "R1 rd_empty", 32'(rd_empty), 1);
        chk(wr_full == !WR_FAST, "R1 wr_full", 32'(wr_full), 32'(!WR_FAST));

        // R9: release reset, write at once; slow side must stay cautious
        first_word = 16'hA5C3;
        rst_n = 1;
        wr_en = WR_FAST; wr_data = first_word;
        rd_en = 1'b0;
        for (int i = 0; i < RATIO; i++) begin
            cyc(0);
            wr_en = 1'b0;
            if (WR_FAST) chk(rd_empty == 1'b1, "R9 rd_empty", 32'(rd_empty), 1);
            else         chk(wr_full == 1'b1, "R9 wr_full", 32'(wr_full), 1);
        end
        repeat (4 * RATIO) cyc(0);
        mq.delete();
        if (WR_FAST) mq.push_back(first_word);
        mfull  = 0;
        mempty = (mq.size() == 0);

        // R4: keep writing past full, no reads
        run((DEPTH + 3) * RATIO, 100, 0);
        chk(wr_full == 1'b1, "R4 full after overfill", 32'(wr_full), 1);
        chk(mq.size() == DEPTH, "R4 model depth", 32'(mq.size()), 32'(DEPTH));
        // R5: read past empty, no writes; order checked on the way out
        run((DEPTH + 3) * RATIO, 0, 100);
        chk(rd_empty == 1'b1, "R5 empty after overdrain", 32'(rd_empty), 1);
        // R5: a word after empty reads must still come out intact
        run(4 * RATIO, 30, 100);

        // random traffic across densities, wrapping the non-power-of-two depth (R11)
        for (int ph = 0; ph < 8; ph++) begin
            case (ph)
                0: run(400, 90, 20);
                1: run(400, 20, 90);
                2: run(400, 50, 50);
                3: run(400, 100, 100);
                4: run(400, 70, 100);
                5: run(400, 100, 40);
                6: run(400, 10, 10);
                default: run(400, 60, 60);
            endcase
        end
        finish_up();
    end
endmodule